// File: doc/BRIEF.md
# Fine-Grained Translation-Cache Invalidation Decode and Trap Checker

This block sits in the decode stage of a core that has supervisor and hypervisor privilege support. It looks at each 32-bit instruction word and picks out the five fine-grained address-translation-cache operations. Three of them are invalidations: one for supervisor addresses, one for guest virtual addresses and one for guest physical addresses. The other two are pure ordering barriers. The first barrier orders earlier stores ahead of later invalidations. The second orders earlier invalidations ahead of later implicit page-table reads.

For every recognised word the block reports an operation class, the two source register indices and a verdict. The verdict is one of three outcomes: allowed, illegal-instruction exception, or virtual-instruction exception. It forms the verdict from the current privilege level, the virtualization bit and the two virtual-memory trap controls. One trap control comes from the machine level and one from the hypervisor level. The invalidations respect both controls. The ordering barriers have no visible side effects, so neither control traps them.

The result is registered and appears one clock after the input strobe, together with an output valid. Executing the operations is left to other logic. The block does not check ordinary fences or CSR accesses.

Top module: `finv_decode_check`

## Requirements
- R1: A word is recognised only if bits [6:0]=1110011, bits [14:12]=000 and bits [11:7]=00000. Any other word gives out_hit=0, out_class=0 and neither trap flag.
- R2: Bits [31:25]=0001011 give class 1, the supervisor invalidation. out_rs1 carries bits [19:15] (the address register) and out_rs2 carries bits [24:20] (the address-space register).
- R3: Bits [31:25]=0001100 with bits [19:15]=00000 give class 4 (store-to-invalidate barrier) when bits [24:20]=00000, and class 5 (invalidate-to-walk barrier) when bits [24:20]=00001. Any other rs1 or rs2 value with this funct7 is not recognised.
- R4: Bits [31:25]=0010011 give class 2 (guest virtual invalidation) and 0110011 give class 3 (guest physical invalidation). For class 3, out_rs2 names the machine-identifier register.
- R5: Privilege is encoded 0=user, 1=supervisor, 3=machine. With V=0 and privilege 0, every recognised class raises an illegal-instruction exception. The reserved privilege value 2 is also reported as illegal.
- R6: In supervisor mode with V=0 and the machine trap control set, class 1 and class 3 raise an illegal-instruction exception. Class 2 is allowed there.
- R7: In supervisor mode with V=1 and the hypervisor trap control set, class 1 raises a virtual-instruction exception. With that control clear it is allowed.
- R8: With V=1 and privilege below machine, classes 2 and 3 raise a virtual-instruction exception. With V=1 and privilege 0, every recognised class raises a virtual-instruction exception.
- R9: Classes 4 and 5 are allowed in supervisor mode, for either V, whatever the two trap controls are.
- R10: In machine mode every recognised class is allowed and V is ignored.
- R11: With parameter HYP_EN=0, classes 2 and 3 are still reported but raise an illegal-instruction exception in every mode, machine mode included.
- R12: Results are registered. out_valid is in_valid delayed by one clock. Reset clears out_valid. out_illegal and out_virtual are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_instr | input | 32 | Instruction word |
| in_priv | input | 2 | Privilege level (0 user, 1 supervisor, 3 machine) |
| in_virt | input | 1 | Virtualization bit V |
| in_tvm | input | 1 | Machine-level virtual-memory trap control |
| in_vtvm | input | 1 | Hypervisor-level virtual-memory trap control |
| out_valid | output | 1 | Registered result valid |
| out_hit | output | 1 | Word is one of the five operations |
| out_class | output | 3 | Operation class code |
| out_rs1 | output | 5 | Address operand register index |
| out_rs2 | output | 5 | Identifier operand register index |
| out_illegal | output | 1 | Raise illegal-instruction exception |
| out_virtual | output | 1 | Raise virtual-instruction exception |

## Verification
The decoder is driven with each of the five encodings and with near-miss words. The near misses have a bad rd, a bad funct3, a bad opcode, a nonzero rs1 on a barrier and an rs2 of 2 on a barrier, and they show that the fixed fields are checked rather than funct7 alone. Each invalidation is swept across user, supervisor and machine mode, with V, the machine trap control and the hypervisor trap control each set and cleared. These sweeps separate the illegal outcome from the virtual one and show which control applies to which class. The same sweep over the barriers shows that they ignore both controls. A second instance built without hypervisor support shows that the guest invalidations become illegal even in machine mode.

// File: rtl/finv_pkg.sv
package finv_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned F7_W    = 7;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
    localparam logic [2:0] F3_PRIV    = 3'b000;

    localparam logic [F7_W-1:0] F7_SUP_INV  = 7'b0001011;
    localparam logic [F7_W-1:0] F7_BARRIER  = 7'b0001100;
    localparam logic [F7_W-1:0] F7_GVA_INV  = 7'b0010011;
    localparam logic [F7_W-1:0] F7_GPA_INV  = 7'b0110011;

    localparam logic [REG_W-1:0] RS2_BAR_WR = 5'd0;
    localparam logic [REG_W-1:0] RS2_BAR_RD = 5'd1;

    typedef enum logic [2:0] {
        CLS_NONE    = 3'd0,
        CLS_SUP_INV = 3'd1,
        CLS_GVA_INV = 3'd2,
        CLS_GPA_INV = 3'd3,
        CLS_BAR_WR  = 3'd4,
        CLS_BAR_RD  = 3'd5
    } op_class_e;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        VERD_ALLOW   = 2'd0,
        VERD_ILLEGAL = 2'd1,
        VERD_VIRTUAL = 2'd2
    } verdict_e;

    typedef struct packed {
        logic            hit;
        op_class_e       cls;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
    } dec_t;

    typedef struct packed {
        logic            hit;
        op_class_e       cls;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic            illegal;
        logic            virt;
    } result_t;

    function automatic logic is_guest(op_class_e c);
        return (c == CLS_GVA_INV) || (c == CLS_GPA_INV);
    endfunction

    function automatic logic is_barrier(op_class_e c);
        return (c == CLS_BAR_WR) || (c == CLS_BAR_RD);
    endfunction

endpackage

// File: rtl/finv_field_decode.sv
module finv_field_decode
    import finv_pkg::*;
#(
    parameter bit HYP_EN = 1'b1
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [F7_W-1:0]  f7;
    logic [REG_W-1:0] rs1_f;
    logic [REG_W-1:0] rs2_f;
    logic             frame_ok;
    op_class_e        cls;

    assign f7     = instr[31:25];
    assign rs2_f  = instr[24:20];
    assign rs1_f  = instr[19:15];
    assign frame_ok = (instr[6:0] == OPC_SYSTEM) && (instr[14:12] == F3_PRIV)
                    && (instr[11:7] == '0);

    always_comb begin
        cls = CLS_NONE;
        if (frame_ok) begin
            unique case (f7)
                F7_SUP_INV: cls = CLS_SUP_INV;
                F7_GVA_INV: cls = CLS_GVA_INV;
                F7_GPA_INV: cls = CLS_GPA_INV;
                F7_BARRIER: begin
                    if (rs1_f == '0 && rs2_f == RS2_BAR_WR)      cls = CLS_BAR_WR;
                    else if (rs1_f == '0 && rs2_f == RS2_BAR_RD) cls = CLS_BAR_RD;
                    else                                         cls = CLS_NONE;
                end
                default: cls = CLS_NONE;
            endcase
        end
    end

    always_comb begin
        dec.hit = (cls != CLS_NONE);
        dec.cls = cls;
        dec.rs1 = dec.hit ? rs1_f : '0;
        dec.rs2 = dec.hit ? rs2_f : '0;
    end

    // R1: a recognised word always carries the privileged system frame
    always_comb begin
        assert_frame_fields_R1: assert (!dec.hit || frame_ok);
    end
endmodule

// File: rtl/finv_priv_rules.sv
module finv_priv_rules
    import finv_pkg::*;
#(
    parameter bit HYP_EN = 1'b1
) (
    input  op_class_e cls,
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       tvm,
    input  logic       vtvm,
    output verdict_e   verdict
);
    priv_e p;
    assign p = priv_e'(priv);

    always_comb begin
        verdict = VERD_ALLOW;
        if (cls == CLS_NONE) begin
            verdict = VERD_ALLOW;
        end else if (!HYP_EN && is_guest(cls)) begin
            verdict = VERD_ILLEGAL;                       // R11
        end else if (p == PRV_MACH) begin
            verdict = VERD_ALLOW;                         // R10
        end else if (p == PRV_RSVD) begin
            verdict = VERD_ILLEGAL;
        end else if (virt) begin
            if (is_guest(cls) || p == PRV_USER)
                verdict = VERD_VIRTUAL;                   // R8
            else if (cls == CLS_SUP_INV && vtvm)
                verdict = VERD_VIRTUAL;                   // R7
            else
                verdict = VERD_ALLOW;
        end else begin
            if (p == PRV_USER)
                verdict = VERD_ILLEGAL;                   // R5
            else if (tvm && (cls == CLS_SUP_INV || cls == CLS_GPA_INV))
                verdict = VERD_ILLEGAL;                   // R6
            else
                verdict = VERD_ALLOW;
        end
    end

    // R9: barriers in supervisor mode are never trapped
    always_comb begin
        assert_barrier_free_R9: assert (!(is_barrier(cls) && p == PRV_SUPER)
                                         || verdict == VERD_ALLOW);
    end
endmodule

// File: rtl/finv_result_reg.sv
module finv_result_reg
    import finv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    d_valid,
    input  result_t d_res,
    output logic    q_valid,
    output result_t q_res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_res   <= '0;
        end else begin
            q_valid <= d_valid;
            if (d_valid) q_res <= d_res;
        end
    end

    assert_valid_follow_R12: assert property (@(posedge clk) disable iff (rst)
        d_valid |=> q_valid);
    assert_valid_drop_R12: assert property (@(posedge clk) disable iff (rst)
        !d_valid |=> !q_valid);
    assert_trap_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> !(q_res.illegal && q_res.virt));
endmodule

// File: rtl/finv_decode_check.sv
module finv_decode_check
    import finv_pkg::*;
#(
    parameter bit HYP_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_instr,
    input  logic [1:0]  in_priv,
    input  logic        in_virt,
    input  logic        in_tvm,
    input  logic        in_vtvm,
    output logic        out_valid,
    output logic        out_hit,
    output logic [2:0]  out_class,
    output logic [4:0]  out_rs1,
    output logic [4:0]  out_rs2,
    output logic        out_illegal,
    output logic        out_virtual
);
    dec_t     dec;
    verdict_e verdict;
    result_t  res_d;
    result_t  res_q;

    finv_field_decode #(.HYP_EN(HYP_EN)) u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    finv_priv_rules #(.HYP_EN(HYP_EN)) u_rules (
        .cls     (dec.cls),
        .priv    (in_priv),
        .virt    (in_virt),
        .tvm     (in_tvm),
        .vtvm    (in_vtvm),
        .verdict (verdict)
    );

    always_comb begin
        res_d.hit     = dec.hit;
        res_d.cls     = dec.cls;
        res_d.rs1     = dec.rs1;
        res_d.rs2     = dec.rs2;
        res_d.illegal = (verdict == VERD_ILLEGAL);
        res_d.virt    = (verdict == VERD_VIRTUAL);
    end

    finv_result_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .d_valid (in_valid),
        .d_res   (res_d),
        .q_valid (out_valid),
        .q_res   (res_q)
    );

    assign out_hit     = res_q.hit;
    assign out_class   = res_q.cls;
    assign out_rs1     = res_q.rs1;
    assign out_rs2     = res_q.rs2;
    assign out_illegal = res_q.illegal;
    assign out_virtual = res_q.virt;

    assert_machine_no_virtual_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_priv == 2'd3) |=> !out_virtual);
    assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec.hit) |=> (!out_hit && !out_illegal && !out_virtual));
endmodule

// File: tb/finv_decode_check_tb.sv
module finv_decode_check_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_instr;
    logic [1:0]  in_priv;
    logic        in_virt, in_tvm, in_vtvm;
    logic        out_valid, out_hit, out_illegal, out_virtual;
    logic [2:0]  out_class;
    logic [4:0]  out_rs1, out_rs2;
    logic        nh_valid, nh_hit, nh_illegal, nh_virtual;
    logic [2:0]  nh_class;
    logic [4:0]  nh_rs1, nh_rs2;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    finv_decode_check u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_priv(in_priv), .in_virt(in_virt), .in_tvm(in_tvm), .in_vtvm(in_vtvm),
        .out_valid(out_valid), .out_hit(out_hit), .out_class(out_class),
        .out_rs1(out_rs1), .out_rs2(out_rs2), .out_illegal(out_illegal),
        .out_virtual(out_virtual));

    finv_decode_check #(.HYP_EN(1'b0)) u_dut_nohyp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_priv(in_priv), .in_virt(in_virt), .in_tvm(in_tvm), .in_vtvm(in_vtvm),
        .out_valid(nh_valid), .out_hit(nh_hit), .out_class(nh_class),
        .out_rs1(nh_rs1), .out_rs2(nh_rs2), .out_illegal(nh_illegal),
        .out_virtual(nh_virtual));

    localparam logic [6:0] F_SUP = 7'b0001011;
    localparam logic [6:0] F_BAR = 7'b0001100;
    localparam logic [6:0] F_GVA = 7'b0010011;
    localparam logic [6:0] F_GPA = 7'b0110011;

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs2,
                                       input logic [4:0] rs1);
        return {f7, rs2, rs1, 3'b000, 5'd0, 7'b1110011};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, sample 1 ns after the capturing posedge
    task automatic apply(input logic [31:0] w, input logic [1:0] p, input logic v,
                         input logic t, input logic vt);
        @(negedge clk);
        in_valid = 1'b1; in_instr = w; in_priv = p; in_virt = v; in_tvm = t; in_vtvm = vt;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    // expected verdict: 0 allow, 1 illegal, 2 virtual
    task automatic expect_verdict(input string tag, input logic [1:0] ev);
        chk({tag, " valid"}, 32'(out_valid), 32'd1);
        chk({tag, " illegal"}, 32'(out_illegal), 32'(ev == 2'd1));
        chk({tag, " virtual"}, 32'(out_virtual), 32'(ev == 2'd2));
    endtask

    task automatic t_reset;
        chk("R12 reset out_valid", 32'(out_valid), 32'd0);
        chk("R12 reset nohyp valid", 32'(nh_valid), 32'd0);
    endtask

    task automatic t_decode;
        apply(mk(F_SUP, 5'd9, 5'd17), 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R2 class", 32'(out_class), 32'd1);
        chk("R2 rs1", 32'(out_rs1), 32'd17);
        chk("R2 rs2", 32'(out_rs2), 32'd9);
        chk("R2 hit", 32'(out_hit), 32'd1);
        apply(mk(F_BAR, 5'd0, 5'd0), 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R3 barrier wr class", 32'(out_class), 32'd4);
        apply(mk(F_BAR, 5'd1, 5'd0), 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R3 barrier rd class", 32'(out_class), 32'd5);
        apply(mk(F_GVA, 5'd3, 5'd4), 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R4 gva class", 32'(out_class), 32'd2);
        apply(mk(F_GPA, 5'd30, 5'd1), 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R4 gpa class", 32'(out_class), 32'd3);
        chk("R4 gpa vmid reg", 32'(out_rs2), 32'd30);
    endtask

    task automatic t_near_miss;
        logic [31:0] w;
        w = mk(F_SUP, 5'd2, 5'd3); w[11:7] = 5'd1;
        apply(w, 2'd0, 1'b0, 1'b0, 1'b0);
        chk("R1 bad rd hit", 32'(out_hit), 32'd0);
        chk("R1 bad rd illegal", 32'(out_illegal), 32'd0);
        w = mk(F_GVA, 5'd2, 5'd3); w[14:12] = 3'b001;
        apply(w, 2'd1, 1'b1, 1'b0, 1'b0);
        chk("R1 bad funct3 hit", 32'(out_hit), 32'd0);
        chk("R1 bad funct3 virtual", 32'(out_virtual), 32'd0);
        w = mk(F_SUP, 5'd2, 5'd3); w[6:0] = 7'b0110011;
        apply(w, 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R1 bad opcode class", 32'(out_class), 32'd0);
        apply(mk(F_BAR, 5'd0, 5'd5), 2'd0, 1'b0, 1'b0, 1'b0);
        chk("R3 barrier rs1 nonzero hit", 32'(out_hit), 32'd0);
        chk("R3 barrier rs1 nonzero illegal", 32'(out_illegal), 32'd0);
        apply(mk(F_BAR, 5'd2, 5'd0), 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R3 barrier rs2=2 class", 32'(out_class), 32'd0);
    endtask

    task automatic t_user;
        apply(mk(F_SUP, 5'd1, 5'd1), 2'd0, 1'b0, 1'b0, 1'b0);
        expect_verdict("R5 user sup-inv", 2'd1);
        apply(mk(F_BAR, 5'd1, 5'd0), 2'd0, 1'b0, 1'b0, 1'b0);
        expect_verdict("R5 user barrier", 2'd1);
        apply(mk(F_GPA, 5'd1, 5'd1), 2'd2, 1'b0, 1'b0, 1'b0);
        expect_verdict("R5 reserved priv", 2'd1);
        apply(mk(F_BAR, 5'd0, 5'd0), 2'd0, 1'b1, 1'b0, 1'b0);
        expect_verdict("R8 virtual user barrier", 2'd2);
    endtask

    task automatic t_tvm;
        apply(mk(F_SUP, 5'd1, 5'd1), 2'd1, 1'b0, 1'b1, 1'b0);
        expect_verdict("R6 hs tvm sup-inv", 2'd1);
        apply(mk(F_GPA, 5'd1, 5'd1), 2'd1, 1'b0, 1'b1, 1'b0);
        expect_verdict("R6 hs tvm gpa", 2'd1);
        apply(mk(F_GVA, 5'd1, 5'd1), 2'd1, 1'b0, 1'b1, 1'b0);
        expect_verdict("R6 hs tvm gva allowed", 2'd0);
        apply(mk(F_SUP, 5'd1, 5'd1), 2'd1, 1'b0, 1'b0, 1'b1);
        expect_verdict("R6 hs vtvm only allowed", 2'd0);
    endtask

    task automatic t_vs;
        apply(mk(F_SUP, 5'd1, 5'd1), 2'd1, 1'b1, 1'b0, 1'b1);
        expect_verdict("R7 vs vtvm sup-inv", 2'd2);
        apply(mk(F_SUP, 5'd1, 5'd1), 2'd1, 1'b1, 1'b1, 1'b0);
        expect_verdict("R7 vs tvm only allowed", 2'd0);
        apply(mk(F_GVA, 5'd1, 5'd1), 2'd1, 1'b1, 1'b0, 1'b0);
        expect_verdict("R8 vs gva", 2'd2);
        apply(mk(F_GPA, 5'd1, 5'd1), 2'd1, 1'b1, 1'b1, 1'b1);
        expect_verdict("R8 vs gpa", 2'd2);
    endtask

    task automatic t_barrier;
        for (int k = 0; k < 8; k++) begin
            apply(mk(F_BAR, 5'(k & 1), 5'd0), 2'd1, k[1], k[2], 1'b1);
            expect_verdict("R9 barrier in supervisor", 2'd0);
        end
    endtask

    task automatic t_machine;
        apply(mk(F_GPA, 5'd1, 5'd1), 2'd3, 1'b1, 1'b1, 1'b1);
        expect_verdict("R10 machine gpa", 2'd0);
        apply(mk(F_SUP, 5'd1, 5'd1), 2'd3, 1'b0, 1'b1, 1'b1);
        expect_verdict("R10 machine sup-inv", 2'd0);
    endtask

    task automatic t_nohyp;
        apply(mk(F_GVA, 5'd1, 5'd1), 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R11 nohyp gva class", 32'(nh_class), 32'd2);
        chk("R11 nohyp gva illegal in machine", 32'(nh_illegal), 32'd1);
        apply(mk(F_GPA, 5'd1, 5'd1), 2'd1, 1'b1, 1'b0, 1'b0);
        chk("R11 nohyp gpa illegal not virtual", 32'(nh_illegal), 32'd1);
        chk("R11 nohyp gpa virtual", 32'(nh_virtual), 32'd0);
        apply(mk(F_SUP, 5'd1, 5'd1), 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R11 nohyp sup-inv allowed", 32'(nh_illegal), 32'd0);
    endtask

    task automatic t_timing;
        apply(mk(F_SUP, 5'd1, 5'd1), 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R12 valid after strobe", 32'(out_valid), 32'd1);
        @(posedge clk); #1;
        chk("R12 valid drops", 32'(out_valid), 32'd0);
    endtask

    initial begin
        in_valid = 0; in_instr = '0; in_priv = 0; in_virt = 0; in_tvm = 0; in_vtvm = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_decode();
        t_near_miss();
        t_user();
        t_tvm();
        t_vs();
        t_barrier();
        t_machine();
        t_nohyp();
        t_timing();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule